// File: doc/BRIEF.md
# POST Code Byte Assembler

This block turns the byte writes a host makes to a diagnostic progress port into whole multi-byte progress codes. Each host write carries up to four bytes together with the byte offset of its first byte. The block splits the write into single-byte entries, each tagged with its own offset, and queues them in a small FIFO. A drain stage then pulls one entry per clock and places its byte in the matching byte lane of a 32-bit accumulator.

A code is complete when the entry after the one being merged carries offset zero, which marks the start of a new code. It is also complete when the entry being merged is the only one stored. A finished code leaves on `code_o` with a one-cycle `code_valid_o` strobe. Three flags report the block's condition: one shows that entries are stored, one latches a write dropped for lack of room, and one latches that a host write has arrived. Software clears the last two by writing 1.

The drain is a two-state machine. ACC_CLEAR means the accumulator holds no partial code, so the next byte is merged onto zero. ACC_PART means a partial code is held. There are four transitions. CONTINUE (ACC_CLEAR to ACC_PART) and EXTEND (ACC_PART to ACC_PART) pop an entry that does not end a code. CLOSE (ACC_PART to ACC_CLEAR) and SINGLE (ACC_CLEAR to ACC_CLEAR, a one-entry code) pop an entry that ends a code. With nothing stored, the state holds.

Top module: `post_code_assembler`

## Requirements
- R1: While `rst_n` is low and right after it rises, `code_valid_o`, `fifo_nempty_o`, `overflow_o` and `write_pend_o` are 0, and the FIFO is empty.
- R2: A write with `wr_valid_i`=1 splits into entries. For each i below `wr_len_i`, byte i (`wr_data_i[8i+7:8i]`) becomes an entry with offset `wr_offset_i`+i. Bytes whose offset would exceed 3 are discarded, and a length of 0 stores nothing.
- R3: The FIFO holds 16 entries. If a write has more entries than there are free slots (16 minus the entries stored before that edge; a pop at the same edge does not count), all of its entries are discarded and `overflow_o` is set at that edge.
- R4: While entries are stored, exactly one is popped at each clock edge, oldest first. `fifo_nempty_o` is 1 exactly when at least one entry is stored.
- R5: A popped entry's byte replaces bits [8·offset+7 : 8·offset] of the code being built. Lanes of a code that no entry wrote are 0.
- R6: If the stored entry after the popped one has offset 0, the code is finished. `code_valid_o` is 1 for the cycle following that edge, with the code on `code_o`.
- R7: If the popped entry was the only stored entry, the code is finished and emitted as in R6.
- R8: After a code is emitted, the next stored entry starts a fresh code at the very next edge, so codes can be emitted on consecutive cycles.
- R9: `overflow_o` stays set until `ovf_clr_i`=1 at an edge. A new drop at that same edge keeps it set.
- R10: `write_pend_o` is set at every edge with `wr_valid_i`=1, including dropped writes and length 0. It is cleared by `pend_clr_i`=1 at an edge with no write, and a write at that edge wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid_i | input | 1 | Host write strobe |
| wr_offset_i | input | 2 | Offset of the first byte of the write |
| wr_len_i | input | 3 | Number of bytes carried (0 to 4) |
| wr_data_i | input | 32 | Write bytes, byte i in bits 8i+7:8i |
| ovf_clr_i | input | 1 | Write-1 clear of the overflow flag |
| pend_clr_i | input | 1 | Write-1 clear of the write-pending flag |
| code_valid_o | output | 1 | One-cycle strobe for a finished code |
| code_o | output | 32 | Finished code, valid with the strobe |
| fifo_nempty_o | output | 1 | At least one entry stored |
| overflow_o | output | 1 | A write was dropped for lack of room |
| write_pend_o | output | 1 | A host write has arrived since the last clear |

## Verification
The cycle of interest is the one in which a code is closed and the first byte of the next code is merged. Both happen at the same edge, and the drain must neither lose that byte nor fold it into the old code. Back-to-back four-byte writes keep the FIFO full enough that every fourth pop closes a code while the head of the next one waits. A run of single-byte writes to offsets 0 to 3, issued behind a preload, must rebuild one code across separate writes. A cycle-level reference model in the bench predicts every strobe, code, fill flag and sticky flag from the requirements alone. The same-edge collisions of a drop with an overflow clear, and of a write with a pending clear, are also driven and judged.

// File: rtl/pca_pkg.sv
package pca_pkg;
    localparam int LANES  = 4;
    localparam int OFF_W  = $clog2(LANES);
    localparam int NUM_W  = $clog2(LANES + 1);
    localparam int CODE_W = 8 * LANES;

    typedef struct packed {
        logic [OFF_W-1:0] off;
        logic [7:0]       data;
    } pca_entry_t;

    typedef enum logic {
        ACC_CLEAR = 1'b0,
        ACC_PART  = 1'b1
    } pca_state_t;
endpackage

// File: rtl/pca_entry_fifo.sv
module pca_entry_fifo
    import pca_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_req,
    input  logic [NUM_W-1:0]        wr_num,
    input  pca_entry_t [LANES-1:0]  wr_ent,
    input  logic                    pop,
    output pca_entry_t              head_ent,
    output logic [OFF_W-1:0]        next_off,
    output logic [CNT_W-1:0]        level,
    output logic                    wr_drop
);
    pca_entry_t       mem [DEPTH];
    logic [PTR_W-1:0] rptr, wptr;
    logic [CNT_W-1:0] room;
    logic             wr_ok;
    pca_entry_t       next_ent;

    assign room     = CNT_W'(DEPTH) - level;
    assign wr_ok    = wr_req && (CNT_W'(wr_num) <= room);
    assign wr_drop  = wr_req && !wr_ok;
    assign head_ent = mem[rptr];
    assign next_ent = mem[rptr + PTR_W'(1)];
    assign next_off = next_ent.off;

    always_ff @(posedge clk) begin
        if (wr_ok) begin
            for (int i = 0; i < LANES; i++) begin
                if (NUM_W'(i) < wr_num) mem[wptr + PTR_W'(i)] <= wr_ent[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rptr  <= '0;
            wptr  <= '0;
            level <= '0;
        end else begin
            if (wr_ok) wptr <= wptr + PTR_W'(wr_num);
            if (pop)   rptr <= rptr + PTR_W'(1);
            level <= level + (wr_ok ? CNT_W'(wr_num) : '0) - CNT_W'(pop);
        end
    end

    p_level_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CNT_W'(DEPTH));
    p_drop_no_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_drop |=> level == $past(level) - CNT_W'($past(pop)));
    p_pop_nonempty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> level != '0);
endmodule

// File: rtl/pca_merge_fsm.sv
module pca_merge_fsm
    import pca_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  level,
    input  pca_entry_t        head_ent,
    input  logic [OFF_W-1:0]  next_off,
    output logic              pop,
    output logic              code_valid,
    output logic [CODE_W-1:0] code
);
    pca_state_t        state, state_nx;
    logic [CODE_W-1:0] acc, base, merged;
    logic              close_now;

    assign pop       = (level != '0);
    assign close_now = pop && ((level == CNT_W'(1)) || (next_off == '0));
    assign base      = (state == ACC_PART) ? acc : '0;

    always_comb begin
        merged = base;
        for (int i = 0; i < LANES; i++) begin
            if (head_ent.off == OFF_W'(i)) merged[8*i +: 8] = head_ent.data;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ACC_CLEAR: if (pop && !close_now) state_nx = ACC_PART;
            ACC_PART:  if (close_now)         state_nx = ACC_CLEAR;
            default:                          state_nx = ACC_CLEAR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ACC_CLEAR;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc        <= '0;
            code       <= '0;
            code_valid <= 1'b0;
        end else begin
            code_valid <= close_now;
            if (close_now) code <= merged;
            if (pop)       acc  <= close_now ? '0 : merged;
        end
    end

    p_part_has_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ACC_PART) |-> level != '0);
    p_valid_after_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        code_valid |-> $past(pop));
endmodule

// File: rtl/pca_status_flags.sv
module pca_status_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_valid,
    input  logic wr_drop,
    input  logic ovf_clr,
    input  logic pend_clr,
    output logic overflow,
    output logic pending
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overflow <= 1'b0;
            pending  <= 1'b0;
        end else begin
            if (wr_drop)      overflow <= 1'b1;
            else if (ovf_clr) overflow <= 1'b0;
            if (wr_valid)      pending <= 1'b1;
            else if (pend_clr) pending <= 1'b0;
        end
    end

    p_pending_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> pending);
    p_ovf_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_clr && !wr_drop) |=> !overflow);
    p_ovf_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_drop |=> overflow);
endmodule

// File: rtl/post_code_assembler.sv
module post_code_assembler
    import pca_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_valid_i,
    input  logic [1:0]  wr_offset_i,
    input  logic [2:0]  wr_len_i,
    input  logic [31:0] wr_data_i,
    input  logic        ovf_clr_i,
    input  logic        pend_clr_i,
    output logic        code_valid_o,
    output logic [31:0] code_o,
    output logic        fifo_nempty_o,
    output logic        overflow_o,
    output logic        write_pend_o
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [NUM_W-1:0]       space, num;
    pca_entry_t [LANES-1:0] ent;
    pca_entry_t             head_ent;
    logic [OFF_W-1:0]       next_off;
    logic [CNT_W-1:0]       level;
    logic                   wr_drop, pop;

    assign space = NUM_W'(LANES) - NUM_W'(wr_offset_i);
    assign num   = (NUM_W'(wr_len_i) < space) ? NUM_W'(wr_len_i) : space;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign ent[g].off  = wr_offset_i + OFF_W'(g);
        assign ent[g].data = wr_data_i[8*g +: 8];
    end

    pca_entry_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_req   (wr_valid_i),
        .wr_num   (num),
        .wr_ent   (ent),
        .pop      (pop),
        .head_ent (head_ent),
        .next_off (next_off),
        .level    (level),
        .wr_drop  (wr_drop)
    );

    pca_merge_fsm #(.CNT_W(CNT_W)) u_merge (
        .clk        (clk),
        .rst_n      (rst_n),
        .level      (level),
        .head_ent   (head_ent),
        .next_off   (next_off),
        .pop        (pop),
        .code_valid (code_valid_o),
        .code       (code_o)
    );

    pca_status_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (wr_valid_i),
        .wr_drop  (wr_drop),
        .ovf_clr  (ovf_clr_i),
        .pend_clr (pend_clr_i),
        .overflow (overflow_o),
        .pending  (write_pend_o)
    );

    assign fifo_nempty_o = (level != '0);

    p_nempty_drains_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_nempty_o && !wr_valid_i && level == CNT_W'(1)) |=> !fifo_nempty_o);
endmodule

// File: tb/post_code_assembler_tb_top.sv
module post_code_assembler_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_valid_i;
    logic [1:0]  wr_offset_i;
    logic [2:0]  wr_len_i;
    logic [31:0] wr_data_i;
    logic        ovf_clr_i, pend_clr_i;
    logic        code_valid_o, fifo_nempty_o, overflow_o, write_pend_o;
    logic [31:0] code_o;

    int total = 0;
    int bad   = 0;

    logic [7:0]  md [256];
    int          mo [256];
    int          mh = 0, mt = 0;
    logic [31:0] macc = '0;
    bit          mpart = 0;
    bit          movf = 0, mpend = 0;
    bit          ev = 0, prev_ev = 0;
    bit          ev_single = 0;
    logic [31:0] ecode = '0;

    always #5 clk = ~clk;

    post_code_assembler dut_i (
        .clk(clk), .rst_n(rst_n), .wr_valid_i(wr_valid_i), .wr_offset_i(wr_offset_i),
        .wr_len_i(wr_len_i), .wr_data_i(wr_data_i), .ovf_clr_i(ovf_clr_i),
        .pend_clr_i(pend_clr_i), .code_valid_o(code_valid_o), .code_o(code_o),
        .fifo_nempty_o(fifo_nempty_o), .overflow_o(overflow_o), .write_pend_o(write_pend_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model(input bit wv, input int off, input int len, input logic [31:0] d,
                         input bit oc, input bit pc);
        int cnt, n;
        logic [31:0] b;
        bit drop;
        cnt = mt - mh;
        prev_ev = ev;
        ev = 0;
        ev_single = 0;
        if (cnt > 0) begin
            b = mpart ? macc : 32'h0;
            b[8*mo[mh%256] +: 8] = md[mh%256];
            if (cnt == 1 || mo[(mh+1)%256] == 0) begin
                ev = 1; ecode = b; mpart = 0; macc = '0; ev_single = (cnt == 1);
            end else begin
                macc = b; mpart = 1;
            end
            mh++;
        end
        drop = 0;
        if (wv) begin
            n = len;
            if (4 - off < n) n = 4 - off;
            if (n <= 16 - cnt) begin
                for (int i = 0; i < n; i++) begin
                    md[mt%256] = d[8*i +: 8];
                    mo[mt%256] = off + i;
                    mt++;
                end
            end else drop = 1;
        end
        if (drop) movf = 1; else if (oc) movf = 0;
        if (wv) mpend = 1; else if (pc) mpend = 0;
    endtask

    task automatic cyc(input bit wv, input int off, input int len, input logic [31:0] d,
                       input bit oc, input bit pc);
        @(negedge clk);
        wr_valid_i = wv; wr_offset_i = 2'(off); wr_len_i = 3'(len); wr_data_i = d;
        ovf_clr_i = oc; pend_clr_i = pc;
        model(wv, off, len, d, oc, pc);
        @(posedge clk);
        #1;
        if (ev && prev_ev)  check("R8 back-to-back strobe", 32'(code_valid_o), 32'(ev));
        else if (ev_single) check("R7 last-entry strobe", 32'(code_valid_o), 32'(ev));
        else                check("R6 strobe", 32'(code_valid_o), 32'(ev));
        if (ev) check("R2 R5 code value", code_o, ecode);
        check("R4 nonempty", 32'(fifo_nempty_o), 32'(mt - mh > 0));
        check("R3 R9 overflow", 32'(overflow_o), 32'(movf));
        check("R10 pending", 32'(write_pend_o), 32'(mpend));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 32'h0, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 0; wr_valid_i = 0; wr_offset_i = 0; wr_len_i = 0; wr_data_i = 0;
        ovf_clr_i = 0; pend_clr_i = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R1 reset strobe", 32'(code_valid_o), 0);
        check("R1 reset nonempty", 32'(fifo_nempty_o), 0);
        rst_n = 1;
        @(posedge clk); #1;
        check("R1 reset overflow", 32'(overflow_o), 0);
        check("R1 reset pending", 32'(write_pend_o), 0);
        check("R1 reset nonempty after", 32'(fifo_nempty_o), 0);

        // R2 R5 R7: every offset and length from an empty FIFO
        for (int off = 0; off < 4; off++) begin
            for (int len = 0; len < 6; len++) begin
                cyc(1, off, len, 32'h11223344 ^ (off * 32'h01010101) + len, 0, 0);
                idle(6);
                cyc(0, 0, 0, 0, 0, 1);
            end
        end

        // R6 R8 R3: back-to-back full writes fill and overflow the FIFO
        for (int k = 0; k < 7; k++) cyc(1, 0, 4, 32'hA0B0C0D0 + k, 0, 0);
        cyc(1, 0, 4, 32'h5, 1, 0);      // R9: drop wins over clear
        idle(24);
        cyc(0, 0, 0, 0, 1, 1);          // R9 R10 clears

        // R6: separate single-byte writes merged behind a preload
        cyc(1, 0, 4, 32'h01020304, 0, 0);
        for (int o = 0; o < 4; o++) cyc(1, o, 1, 32'h000000E0 + o, 0, 0);
        cyc(1, 1, 2, 32'h0000BEEF, 0, 1); // R10: write wins over clear
        idle(10);

        // R7: single-byte writes each cycle from empty
        for (int o = 0; o < 4; o++) cyc(1, o, 1, 32'h70 + o, 0, 0);
        idle(8);

        // R2: offset 2 with 4 bytes keeps only two
        cyc(1, 2, 4, 32'hCAFEF00D, 0, 0);
        idle(5);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule